// File: doc/BRIEF.md
# Read-Capture Delay Tap Calibrator

This block searches for the range of delay-tap settings at which a memory reads back correctly, and then parks the tap in the middle of that range. On a start pulse it takes the tap value the lanes are currently programmed with as its home point. It writes a fixed test pattern over a test region through a simple memory port. It then tries candidate taps one at a time. For each candidate it drives both lane tap outputs with that value and reads the whole region back twice, comparing every word against the pattern.

The search first climbs from the home tap until a candidate fails or the climb reaches a hard ceiling. It then returns to the home tap and descends until a candidate fails or tap zero passes. The last passing value in each direction becomes the upper or lower edge of the window. Lane 0 gets the floor of the edges' mean and lane 1 one step above it. The expected data is regenerated from the word address rather than stored. The memory port allows only one read in flight and accepts any read latency.

Top module: `tap_window_cal`

## Requirements
- R1: A start pulse seen while idle latches `start_tap` as the home tap. From the next cycle on, `busy` is high and `upper_bound` and `lower_bound` both equal the home tap.
- R2: Whenever a read is issued during the search, `tap_lane0` and `tap_lane1` carry the same candidate value.
- R3: While climbing, a passing candidate below `TAP_LIMIT` (default 32) is followed by candidate + 1. A passing candidate at or above `TAP_LIMIT` makes it the upper edge and starts the descent from the home tap.
- R4: The first failing candidate of the climb sets the upper edge to that candidate minus one, modulo 2^6. The descent then starts by retesting the home tap.
- R5: While descending, a failing candidate sets the lower edge to that candidate plus one and ends the search. A passing tap 0 sets the lower edge to 0 and ends the search. Any other passing candidate is followed by candidate − 1.
- R6: When the search ends, `tap_lane0` = floor((upper + lower) / 2) and `tap_lane1` = `tap_lane0` + 1. Both hold their values afterwards.
- R7: Before the first candidate, 4·`NUM_IDX` words are written once, in ascending address order from 0. Word w uses index i = w/4 and pair k = w mod 4. Bits [31:16] are all ones when bit 2k+1 of i is 1, and bits [15:0] are all ones when bit 2k of i is 1. Every other bit is zero.
- R8: A candidate passes only after `PASSES` (default 2) complete ascending read passes with no mismatch. The first mismatching word fails the candidate, and no further read is issued for that candidate.
- R9: At most one read is outstanding. A read completes on `mem_rvalid` after any number of cycles.
- R10: `busy` stays high until the cycle in which the final taps are written. `done` is then high for exactly that one cycle, with `busy` low. A start pulse during `busy` has no effect on the result.
- R11: After reset, `busy`, `done` and `mem_req` are low, `tap_lane0` = `RESET_TAP` (default 8) and `tap_lane1` = `RESET_TAP` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration when idle |
| start_tap | input | 6 | Tap currently programmed on lane 0, used as home |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse when the final taps are written |
| tap_lane0 | output | 6 | Delay tap for lane 0 |
| tap_lane1 | output | 6 | Delay tap for lane 1 |
| upper_bound | output | 6 | Upper passing edge found by the search |
| lower_bound | output | 6 | Lower passing edge found by the search |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | log2(4·NUM_IDX) | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The search state is visible at the ports mainly through the sequence of reads and the final taps. A wrong direction flag or candidate step changes how many reads are issued and where the window edges land. A fault in the compare or the pass counter changes the read count of each candidate within one candidate's worth of traffic. The bench therefore models a window of good taps, counts reads and fill writes per run, and checks the edges and taps on the `done` cycle against values worked out from the rules above.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CAL_TAP_W = 6;

    typedef logic [CAL_TAP_W-1:0] tap_t;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_FILL,
        SR_TEST,
        SR_WAIT,
        SR_FINISH
    } srch_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FILL,
        SQ_RREQ,
        SQ_RWAIT
    } seq_state_e;

    // Edges of the passing window
    typedef struct packed {
        tap_t upper;
        tap_t lower;
    } window_t;

    // Sweep position: direction, home point, current candidate
    typedef struct packed {
        logic up;
        tap_t home;
        tap_t cand;
    } sweep_t;

    function automatic tap_t tap_midpoint(window_t w);
        logic [CAL_TAP_W:0] sum;
        sum = {1'b0, w.upper} + {1'b0, w.lower};
        return sum[CAL_TAP_W:1];
    endfunction

endpackage

// File: rtl/cal_pattern_gen.sv
module cal_pattern_gen #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] word_idx,
    output logic [DATA_W-1:0] word
);
    localparam int HALF  = DATA_W / 2;
    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = 8;

    logic [1:0]       pair;
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] idx_ext;

    assign pair = word_idx[1:0];
    assign idx  = word_idx[ADDR_W-1:2];

    generate
        if (IDX_W >= SEL_W) begin : g_wide
            assign idx_ext = idx[SEL_W-1:0];
        end else begin : g_narrow
            assign idx_ext = {{(SEL_W-IDX_W){1'b0}}, idx};
        end
    endgenerate

    assign word = {{HALF{idx_ext[{pair, 1'b1}]}}, {HALF{idx_ext[{pair, 1'b0}]}}};

endmodule

// File: rtl/cal_mem_seq.sv
module cal_mem_seq import cal_pkg::*; #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int NUM_WORDS = 1024,
    parameter int PASSES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_go,
    input  logic              test_go,
    output logic              fill_done,
    output logic              test_done,
    output logic              test_pass,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;

    seq_state_e        st;
    logic [ADDR_W-1:0] widx;
    logic [PASS_W-1:0] pcnt;
    logic [DATA_W-1:0] expect_w;
    logic              last_word;
    logic              last_pass;
    logic              mismatch;
    logic              rd_open;

    cal_pattern_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pat (
        .word_idx (widx),
        .word     (expect_w)
    );

    assign last_word = (widx == ADDR_W'(NUM_WORDS - 1));
    assign last_pass = (pcnt == PASS_W'(PASSES - 1));
    assign mismatch  = (mem_rdata != expect_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            widx      <= '0;
            pcnt      <= '0;
            fill_done <= 1'b0;
            test_done <= 1'b0;
            test_pass <= 1'b0;
        end else begin
            fill_done <= 1'b0;
            test_done <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (fill_go) begin
                        st   <= SQ_FILL;
                        widx <= '0;
                    end else if (test_go) begin
                        st   <= SQ_RREQ;
                        widx <= '0;
                        pcnt <= '0;
                    end
                end
                SQ_FILL: begin
                    widx <= widx + ADDR_W'(1);
                    if (last_word) begin
                        fill_done <= 1'b1;
                        st        <= SQ_IDLE;
                    end
                end
                SQ_RREQ: st <= SQ_RWAIT;
                SQ_RWAIT: begin
                    if (mem_rvalid) begin
                        if (mismatch) begin
                            test_done <= 1'b1;
                            test_pass <= 1'b0;
                            st        <= SQ_IDLE;
                        end else if (last_word) begin
                            if (last_pass) begin
                                test_done <= 1'b1;
                                test_pass <= 1'b1;
                                st        <= SQ_IDLE;
                            end else begin
                                pcnt <= pcnt + PASS_W'(1);
                                widx <= '0;
                                st   <= SQ_RREQ;
                            end
                        end else begin
                            widx <= widx + ADDR_W'(1);
                            st   <= SQ_RREQ;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == SQ_FILL) || (st == SQ_RREQ);
    assign mem_we    = (st == SQ_FILL);
    assign mem_addr  = widx;
    assign mem_wdata = expect_w;

    // Tracks a read in flight, opened by a request and closed by the return
    always_ff @(posedge clk) begin
        if (rst)                     rd_open <= 1'b0;
        else if (mem_req && !mem_we) rd_open <= 1'b1;
        else if (mem_rvalid)         rd_open <= 1'b0;
    end

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !rd_open); // R9

    AST_MISMATCH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_RWAIT && mem_rvalid && mismatch) |=> (!mem_req && test_done && !test_pass)); // R8

    AST_FILL_ONLY_WRITES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !rd_open); // R7

endmodule

// File: rtl/cal_search.sv
module cal_search import cal_pkg::*; #(
    parameter int TAP_LIMIT = 32,
    parameter int RESET_TAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  tap_t start_tap,
    output logic fill_go,
    input  logic fill_done,
    output logic test_go,
    input  logic test_done,
    input  logic test_pass,
    output logic busy,
    output logic done,
    output tap_t tap_lane0,
    output tap_t tap_lane1,
    output tap_t upper_bound,
    output tap_t lower_bound
);
    localparam tap_t LIMIT = tap_t'(TAP_LIMIT);
    localparam tap_t ONE   = tap_t'(1);

    srch_state_e st;
    sweep_t      sw;
    window_t     win;
    tap_t        mid;

    assign mid = tap_midpoint(win);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SR_IDLE;
            sw        <= '0;
            win       <= '0;
            tap_lane0 <= tap_t'(RESET_TAP);
            tap_lane1 <= tap_t'(RESET_TAP + 1);
            busy      <= 1'b0;
            done      <= 1'b0;
            fill_go   <= 1'b0;
            test_go   <= 1'b0;
        end else begin
            done    <= 1'b0;
            fill_go <= 1'b0;
            test_go <= 1'b0;
            case (st)
                SR_IDLE: begin
                    if (start) begin
                        sw.home   <= start_tap;
                        sw.cand   <= start_tap;
                        sw.up     <= 1'b1;
                        win.upper <= start_tap;
                        win.lower <= start_tap;
                        busy      <= 1'b1;
                        fill_go   <= 1'b1;
                        st        <= SR_FILL;
                    end
                end
                SR_FILL: begin
                    if (fill_done) st <= SR_TEST;
                end
                SR_TEST: begin
                    tap_lane0 <= sw.cand;
                    tap_lane1 <= sw.cand;
                    test_go   <= 1'b1;
                    st        <= SR_WAIT;
                end
                SR_WAIT: begin
                    if (test_done) begin
                        st <= SR_TEST;
                        if (!test_pass) begin
                            if (sw.up) begin
                                win.upper <= sw.cand - ONE;
                                sw.cand   <= sw.home;
                                sw.up     <= 1'b0;
                            end else begin
                                win.lower <= sw.cand + ONE;
                                st        <= SR_FINISH;
                            end
                        end else if (sw.up) begin
                            if (sw.cand < LIMIT) begin
                                sw.cand <= sw.cand + ONE;
                            end else begin
                                win.upper <= sw.cand;
                                sw.cand   <= sw.home;
                                sw.up     <= 1'b0;
                            end
                        end else if (sw.cand == '0) begin
                            win.lower <= '0;
                            st        <= SR_FINISH;
                        end else begin
                            sw.cand <= sw.cand - ONE;
                        end
                    end
                end
                SR_FINISH: begin
                    tap_lane0 <= mid;
                    tap_lane1 <= mid + ONE;
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    st        <= SR_IDLE;
                end
                default: st <= SR_IDLE;
            endcase
        end
    end

    assign upper_bound = win.upper;
    assign lower_bound = win.lower;

    AST_LANES_MATCH: assert property (@(posedge clk) disable iff (rst)
        (st == SR_WAIT) |-> (tap_lane0 == tap_lane1)); // R2

    AST_CLIMB_CEILING: assert property (@(posedge clk) disable iff (rst)
        (st == SR_WAIT && sw.up && sw.cand != sw.home) |-> (sw.cand <= LIMIT)); // R3

    AST_DESCENT_FROM_HOME: assert property (@(posedge clk) disable iff (rst)
        $fell(sw.up) |-> (sw.cand == sw.home)); // R4

    AST_LANE1_STEP: assert property (@(posedge clk) disable iff (rst)
        done |-> (tap_lane1 == tap_lane0 + ONE)); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R10

    AST_HOME_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && st != SR_FINISH) |=> $stable(sw.home)); // R10

endmodule

// File: rtl/tap_window_cal.sv
module tap_window_cal import cal_pkg::*; #(
    parameter int DATA_W    = 32,
    parameter int NUM_IDX   = 256,
    parameter int PASSES    = 2,
    parameter int TAP_LIMIT = 32,
    parameter int RESET_TAP = 8,
    localparam int NUM_WORDS = NUM_IDX * 4,
    localparam int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CAL_TAP_W-1:0] start_tap,
    output logic                 busy,
    output logic                 done,
    output logic [CAL_TAP_W-1:0] tap_lane0,
    output logic [CAL_TAP_W-1:0] tap_lane1,
    output logic [CAL_TAP_W-1:0] upper_bound,
    output logic [CAL_TAP_W-1:0] lower_bound,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_rvalid,
    input  logic [DATA_W-1:0]    mem_rdata
);
    logic fill_go, fill_done, test_go, test_done, test_pass;

    cal_search #(.TAP_LIMIT(TAP_LIMIT), .RESET_TAP(RESET_TAP)) u_search (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_tap   (start_tap),
        .fill_go     (fill_go),
        .fill_done   (fill_done),
        .test_go     (test_go),
        .test_done   (test_done),
        .test_pass   (test_pass),
        .busy        (busy),
        .done        (done),
        .tap_lane0   (tap_lane0),
        .tap_lane1   (tap_lane1),
        .upper_bound (upper_bound),
        .lower_bound (lower_bound)
    );

    cal_mem_seq #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS),
        .PASSES    (PASSES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .fill_go    (fill_go),
        .test_go    (test_go),
        .fill_done  (fill_done),
        .test_done  (test_done),
        .test_pass  (test_pass),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata)
    );

    AST_RESULT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (done && lower_bound <= upper_bound) |->
            (tap_lane0 >= lower_bound && tap_lane0 <= upper_bound)); // R6

endmodule

// File: tb/tap_window_cal_test.sv
module tap_window_cal_test;
    localparam int NIDX  = 16;
    localparam int WORDS = NIDX * 4;
    localparam int AW    = $clog2(WORDS);
    localparam int NV    = 6;
    // start, good_lo, good_hi, exp_upper, exp_lower, passing candidates, failing candidates
    localparam int VEC [NV][7] = '{
        '{12, 10, 14, 14, 10,  6, 2},
        '{30, 20, 40, 32, 20, 14, 1},
        '{ 3,  0,  5,  5,  0,  7, 1},
        '{ 7,  7,  7,  7,  7,  2, 2},
        '{ 9, 10, 20,  8, 10,  0, 2},
        '{40,  0, 63, 40,  0, 42, 0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [5:0]    start_tap = '0;
    logic          busy, done, mem_req, mem_we;
    logic [5:0]    tap_lane0, tap_lane1, upper_bound, lower_bound;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;

    int total = 0;
    int bad = 0;
    int win_lo = 0;
    int win_hi = 63;

    // model state and running statistics
    logic [31:0] mem [0:WORDS-1];
    logic        rd_pend = 1'b0;
    int          lat_cnt = 0;
    logic [AW-1:0] rd_addr = '0;
    logic        rd_bad = 1'b0;
    int          n_wr = 0, n_wr_bad = 0, n_rd = 0, n_lane_bad = 0, n_ovl = 0;
    int          last_wr = -1;

    always #10 clk = ~clk;

    tap_window_cal #(.DATA_W(32), .NUM_IDX(NIDX)) uut (
        .clk, .rst, .start, .start_tap, .busy, .done, .tap_lane0, .tap_lane1,
        .upper_bound, .lower_bound, .mem_req, .mem_we, .mem_addr, .mem_wdata,
        .mem_rvalid, .mem_rdata
    );

    function automatic logic [31:0] exp_word(int a);
        int i = a / 4;
        int k = a % 4;
        logic [31:0] w = '0;
        if (((i >> (2 * k)) & 1) == 1) w[15:0] = 16'hffff;
        if (((i >> (2 * k + 1)) & 1) == 1) w[31:16] = 16'hffff;
        return w;
    endfunction

    // memory model: variable latency, corrupts data for taps outside the good window
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst) begin
            rd_pend <= 1'b0;
        end else begin
            if (rd_pend) begin
                if (lat_cnt == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= rd_bad ? (mem[rd_addr] ^ 32'h1) : mem[rd_addr];
                    rd_pend    <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
            if (mem_req) begin
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    if (mem_wdata != exp_word(int'(mem_addr))) n_wr_bad++;
                    if (!(int'(mem_addr) == 0 || int'(mem_addr) == last_wr + 1)) n_wr_bad++;
                    last_wr = int'(mem_addr);
                    n_wr++;
                end else begin
                    if (rd_pend) n_ovl++;
                    if (tap_lane0 != tap_lane1) n_lane_bad++;
                    rd_pend <= 1'b1;
                    lat_cnt <= n_rd % 3;
                    rd_addr <= mem_addr;
                    rd_bad  <= (int'(tap_lane0) < win_lo) || (int'(tap_lane0) > win_hi);
                    n_rd++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Runs one calibration; poke_at > 0 pulses a stray start with tap 50 after that many cycles
    task automatic run_cal(input int st_tap, input int lo, input int hi, input int e_up,
                           input int e_lo, input int n_pass, input int n_fail, input int poke_at);
        int wr0, wrb0, rd0, lb0, ov0, cyc, mid;
        win_lo = lo;
        win_hi = hi;
        wr0 = n_wr; wrb0 = n_wr_bad; rd0 = n_rd; lb0 = n_lane_bad; ov0 = n_ovl;
        @(negedge clk);
        start_tap = 6'(st_tap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_tap = 6'd0;
        check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        check(upper_bound == 6'(st_tap) && lower_bound == 6'(st_tap), "R1 bounds at home",
              int'(upper_bound), st_tap);
        cyc = 0;
        while (!done && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            if (poke_at > 0 && cyc == poke_at) begin
                start_tap = 6'd50;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) begin
            check(1'b0, "watchdog", cyc, 60000);
            finish_run();
        end
        mid = (e_up + e_lo) / 2;
        check(upper_bound == 6'(e_up), "R3/R4 upper edge", int'(upper_bound), e_up);
        check(lower_bound == 6'(e_lo), "R5 lower edge", int'(lower_bound), e_lo);
        check(tap_lane0 == 6'(mid), "R6 lane0 midpoint", int'(tap_lane0), mid);
        check(tap_lane1 == 6'(mid + 1), "R6 lane1 step", int'(tap_lane1), mid + 1);
        check(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
        check(n_wr - wr0 == WORDS, "R7 fill word count", n_wr - wr0, WORDS);
        check(n_wr_bad == wrb0, "R7 fill data/order", n_wr_bad - wrb0, 0);
        check(n_rd - rd0 == n_pass * 2 * WORDS + n_fail, "R8 reads per run",
              n_rd - rd0, n_pass * 2 * WORDS + n_fail);
        check(n_lane_bad == lb0, "R2 lanes equal at reads", n_lane_bad - lb0, 0);
        check(n_ovl == ov0, "R9 single outstanding read", n_ovl - ov0, 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", int'(done), 0);
        check(tap_lane0 == 6'(mid) && tap_lane1 == 6'(mid + 1), "R6 taps held",
              int'(tap_lane0), mid);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(busy == 1'b0 && done == 1'b0, "R11 busy/done after reset", int'(busy), 0);
        check(mem_req == 1'b0, "R11 no request after reset", int'(mem_req), 0);
        check(tap_lane0 == 6'd8, "R11 lane0 reset tap", int'(tap_lane0), 8);
        check(tap_lane1 == 6'd9, "R11 lane1 reset tap", int'(tap_lane1), 9);

        for (int v = 0; v < NV; v++) begin
            run_cal(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6], 0);
        end

        // R10: a stray start during the search changes nothing
        run_cal(12, 10, 14, 14, 10, 6, 2, 200);

        // R11: reset in the middle of a search
        win_lo = 20; win_hi = 40;
        @(negedge clk);
        start_tap = 6'd30;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R11 busy cleared by reset", int'(busy), 0);
        check(tap_lane0 == 6'd8 && tap_lane1 == 6'd9, "R11 taps after reset", int'(tap_lane0), 8);
        @(negedge clk);
        check(mem_req == 1'b0, "R11 idle after reset", int'(mem_req), 0);

        finish_run();
    end
endmodule